// File: doc/BRIEF.md
# Receive-Side Width Upsizer

This block sits between an 18-bit receive bus and the write port of a 36-bit FIFO. It gathers narrow transfers in a holding register and writes that register to the FIFO only after every piece of a word has arrived. In word mode, two 18-bit transfers make one entry. In byte mode, four 9-bit transfers make one entry. An endianness input decides which end of the 36-bit word the first piece of each entry lands in.

The block accepts a transfer when `in_valid_i` and `in_ready_o` are both high on a rising clock edge. The cycle after the last piece is accepted, the completed word is presented on `fifo_data_o`. If the FIFO is not full, `fifo_wr_o` pulses for that cycle. While a completed word waits behind a full FIFO, the input is stalled. When the word drains, a new piece can be accepted in the same cycle, so the block sustains one piece per clock. The mode and endianness inputs must stay constant while a word is partially assembled.

Top module: `upsz_top`

## Requirements
- R1: In word mode (`byte_mode_i`=0), two accepted 18-bit transfers form one 36-bit entry, and all 18 input bits are stored.
- R2: In byte mode (`byte_mode_i`=1), four accepted transfers form one entry, each contributing `in_data_i[8:0]`; bits [17:9] have no effect on the written word.
- R3: With `big_endian_i`=0, piece k of an entry (k counted from 0 in arrival order) occupies bits [k*W +: W], where W is 18 in word mode and 9 in byte mode.
- R4: With `big_endian_i`=1, piece k occupies bits [(N-1-k)*W +: W], where N is 2 in word mode and 4 in byte mode.
- R5: `fifo_wr_o` is high for exactly one cycle per completed word. That cycle is the first cycle after the last piece is accepted in which `fifo_full_i` is low. No partial word is ever written.
- R6: `in_ready_o` is low exactly when a completed word is waiting and `fifo_full_i` is high. While it is low, `fifo_data_o` holds the waiting word unchanged.
- R7: In the cycle a completed word is written, `in_ready_o` is high, and a piece accepted in that cycle becomes piece 0 of the next entry.
- R8: An active-low asynchronous reset discards any partial or waiting word. After reset, `fifo_wr_o` is 0 and `in_ready_o` is 1.
- R9: `fifo_wr_o` is never high while `fifo_full_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_mode_i | input | 1 | 0: 18-bit pieces, 1: 9-bit pieces |
| big_endian_i | input | 1 | 1: first piece at the most significant end |
| in_valid_i | input | 1 | Input piece valid |
| in_data_i | input | 18 | Input piece |
| in_ready_o | output | 1 | Block can take a piece |
| fifo_full_i | input | 1 | FIFO cannot take a write |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 36 | Assembled word |

## Verification
The bench builds the block with its default geometry: 9-bit lanes, two lanes on the input and four on the output. This geometry covers both piece counts (2 and 4) and both placement orders. Random valid and FIFO-full patterns force stalls that start on a completed word and drains that coincide with a new piece. Byte-mode pieces carry random upper bits, so any leak of bits [17:9] shows up in the written word. A reset in the middle of a word confirms that the discarded pieces never reach the FIFO.

// File: rtl/upsz_pkg.sv
package upsz_pkg;
  typedef enum logic {MODE_WORD = 1'b0, MODE_BYTE = 1'b1} upsz_mode_e;
endpackage

// File: rtl/upsz_ctrl.sv
module upsz_ctrl #(
  parameter int NP_MAX = 4,
  parameter int NP_MIN = 2,
  localparam int CW = $clog2(NP_MAX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_mode_i,
  input  logic          in_valid_i,
  input  logic          fifo_full_i,
  output logic          in_ready_o,
  output logic          accept_o,
  output logic          drain_o,
  output logic [CW-1:0] slot_o
);
  import upsz_pkg::*;

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          last;

  assign drain_o    = done_q & ~fifo_full_i;
  assign in_ready_o = ~done_q | ~fifo_full_i;
  assign accept_o   = in_valid_i & in_ready_o;
  assign slot_o     = cnt_q;
  assign last = (upsz_mode_e'(byte_mode_i) == MODE_BYTE) ? (cnt_q == CW'(NP_MAX-1))
                                                          : (cnt_q == CW'(NP_MIN-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (accept_o) cnt_q <= last ? '0 : cnt_q + 1'b1;
      // a drain and a completing accept cannot both clear: completion wins
      if (accept_o && last) done_q <= 1'b1;
      else if (drain_o)     done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/upsz_place.sv
module upsz_place #(
  parameter int LANE_W    = 9,
  parameter int IN_LANES  = 2,
  parameter int OUT_LANES = 4,
  localparam int NP_MIN = OUT_LANES / IN_LANES,
  localparam int CW     = $clog2(OUT_LANES),
  localparam int IN_W   = LANE_W * IN_LANES,
  localparam int OUT_W  = LANE_W * OUT_LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_mode_i,
  input  logic             big_endian_i,
  input  logic             accept_i,
  input  logic [CW-1:0]    slot_i,
  input  logic [IN_W-1:0]  in_data_i,
  output logic [OUT_W-1:0] hold_o
);
  import upsz_pkg::*;

  logic          is_byte;
  logic [CW-1:0] pos;

  assign is_byte = upsz_mode_e'(byte_mode_i) == MODE_BYTE;

  always_comb begin
    if (is_byte) pos = big_endian_i ? CW'(OUT_LANES-1) - slot_i : slot_i;
    else         pos = big_endian_i ? CW'(NP_MIN-1) - slot_i : slot_i;
  end

  for (genvar j = 0; j < OUT_LANES; j++) begin : g_lane
    localparam int GRP = j / IN_LANES;
    localparam int SUB = j % IN_LANES;
    logic              lane_we;
    logic [LANE_W-1:0] lane_d;

    assign lane_we = accept_i & (is_byte ? (pos == CW'(j)) : (pos == CW'(GRP)));
    assign lane_d  = is_byte ? in_data_i[LANE_W-1:0] : in_data_i[SUB*LANE_W +: LANE_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hold_o[j*LANE_W +: LANE_W] <= '0;
      else if (lane_we) hold_o[j*LANE_W +: LANE_W] <= lane_d;
    end
  end
endmodule

// File: rtl/upsz_top.sv
module upsz_top #(
  parameter int LANE_W    = 9,
  parameter int IN_LANES  = 2,
  parameter int OUT_LANES = 4,
  localparam int IN_W  = LANE_W * IN_LANES,
  localparam int OUT_W = LANE_W * OUT_LANES,
  localparam int CW    = $clog2(OUT_LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_mode_i,
  input  logic             big_endian_i,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  in_data_i,
  output logic             in_ready_o,
  input  logic             fifo_full_i,
  output logic             fifo_wr_o,
  output logic [OUT_W-1:0] fifo_data_o
);
  logic          accept;
  logic          drain;
  logic [CW-1:0] slot;

  upsz_ctrl #(.NP_MAX(OUT_LANES), .NP_MIN(OUT_LANES / IN_LANES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_mode_i (byte_mode_i),
    .in_valid_i  (in_valid_i),
    .fifo_full_i (fifo_full_i),
    .in_ready_o  (in_ready_o),
    .accept_o    (accept),
    .drain_o     (drain),
    .slot_o      (slot)
  );

  upsz_place #(.LANE_W(LANE_W), .IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES)) u_place (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_mode_i  (byte_mode_i),
    .big_endian_i (big_endian_i),
    .accept_i     (accept),
    .slot_i       (slot),
    .in_data_i    (in_data_i),
    .hold_o       (fifo_data_o)
  );

  assign fifo_wr_o = drain;
endmodule

// File: rtl/upsz_checker.sv
module upsz_checker #(
  parameter int OUT_LANES = 4,
  parameter int IN_LANES  = 2,
  parameter int OUT_W     = 36,
  localparam int AW = $clog2(OUT_LANES + 1) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_mode_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             fifo_full_i,
  input logic             fifo_wr_o,
  input logic [OUT_W-1:0] fifo_data_o
);
  logic [AW-1:0] acc_q;
  logic          acc_in;

  assign acc_in = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   acc_q <= '0;
    else if (fifo_wr_o && acc_in)  acc_q <= AW'(1);
    else if (fifo_wr_o)            acc_q <= '0;
    else if (acc_in)               acc_q <= acc_q + 1'b1;
  end

  a_r9_no_write_into_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !fifo_full_i);

  a_r6_stall_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> fifo_full_i);

  a_r6_pending_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> $stable(fifo_data_o));

  a_r5_whole_word_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> (acc_q == (byte_mode_i ? AW'(OUT_LANES) : AW'(OUT_LANES / IN_LANES))));

  a_r7_ready_on_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> in_ready_o);
endmodule

bind upsz_top upsz_checker #(.OUT_LANES(OUT_LANES), .IN_LANES(IN_LANES), .OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_mode_i (byte_mode_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .fifo_full_i (fifo_full_i),
  .fifo_wr_o   (fifo_wr_o),
  .fifo_data_o (fifo_data_o)
);

// File: tb/upsz_top_test.sv
module upsz_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_mode_i = 1'b0;
  logic        big_endian_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [17:0] in_data_i = '0;
  logic        in_ready_o;
  logic        fifo_full_i = 1'b0;
  logic        fifo_wr_o;
  logic [35:0] fifo_data_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model state
  logic [17:0] q[$];
  bit          pend = 1'b0;
  logic [35:0] pend_word = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  upsz_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_mode_i(byte_mode_i), .big_endian_i(big_endian_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .fifo_full_i(fifo_full_i), .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string data_tag();
    if (byte_mode_i) return big_endian_i ? "R2/R4" : "R2/R3";
    return big_endian_i ? "R1/R4" : "R1/R3";
  endfunction

  function automatic logic [35:0] build_word();
    logic [35:0] w = '0;
    int n = byte_mode_i ? 4 : 2;
    for (int k = 0; k < n; k++) begin
      int pos = big_endian_i ? n - 1 - k : k;
      if (byte_mode_i) w[pos*9 +: 9] = q[k][8:0];
      else             w[pos*18 +: 18] = q[k];
    end
    return w;
  endfunction

  task automatic step(input bit v, input logic [17:0] d, input bit full);
    bit exp_ready, exp_wr;
    @(negedge clk_i);
    in_valid_i = v; in_data_i = d; fifo_full_i = full;
    #1;
    exp_ready = !pend || !full;
    exp_wr    = pend && !full;
    chk(in_ready_o === exp_ready, "R6", 36'(in_ready_o), 36'(exp_ready));
    chk(fifo_wr_o === exp_wr, "R5/R9", 36'(fifo_wr_o), 36'(exp_wr));
    if (pend) chk(fifo_data_o === pend_word, data_tag(), fifo_data_o, pend_word);
    @(posedge clk_i);
    if (exp_wr) pend = 1'b0;
    if (v && exp_ready) begin
      q.push_back(d);
      if (q.size() == (byte_mode_i ? 4 : 2)) begin
        pend_word = build_word();
        pend = 1'b1;
        q.delete();
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; in_valid_i = 1'b0;
    q.delete(); pend = 1'b0;
    #1;
    chk(fifo_wr_o === 1'b0, "R8", 36'(fifo_wr_o), 36'd0);
    chk(in_ready_o === 1'b1, "R8", 36'(in_ready_o), 36'd1);
    chk(fifo_data_o === '0, "R8", fifo_data_o, 36'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // complete any partial word and drain it, so settings may change
  task automatic flush();
    while (q.size() != 0 || pend) step(q.size() != 0, 18'($urandom), 1'b0);
    step(1'b0, '0, 1'b0);
  endtask

  task automatic run_mode(input bit bm, input bit be, input int cycles, input int full_pct);
    flush();
    @(negedge clk_i);
    byte_mode_i = bm; big_endian_i = be;
    for (int i = 0; i < cycles; i++)
      step(($urandom % 100) < 70, 18'($urandom), ($urandom % 100) < full_pct);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1/R3 directed: word little-endian
    step(1, 18'h3_0001, 0); step(1, 18'h2_ABCD, 0);
    step(0, '0, 0);
    // R4 directed: word big-endian
    flush(); @(negedge clk_i); big_endian_i = 1'b1;
    step(1, 18'h1_1111, 0); step(1, 18'h2_2222, 0); step(0, '0, 0);
    // R2 directed: byte mode with junk in upper bits, big-endian
    flush(); @(negedge clk_i); byte_mode_i = 1'b1;
    step(1, 18'h3FE01, 0); step(1, 18'h3FE02, 0); step(1, 18'h3FE03, 0); step(1, 18'h3FE04, 1);
    // R6 stall then R7 drain with new piece
    step(1, 18'h00055, 1); step(1, 18'h00066, 1); step(1, 18'h00077, 0);
    // R8 reset mid-word
    step(1, 18'h00012, 0);
    do_reset();
    @(negedge clk_i); byte_mode_i = 1'b0; big_endian_i = 1'b0;
    step(1, 18'h0AAAA, 0); step(1, 18'h15555, 0); step(0, '0, 0);
    // random sweeps over all four settings
    run_mode(0, 0, 400, 30);
    run_mode(0, 1, 400, 30);
    run_mode(1, 0, 400, 30);
    run_mode(1, 1, 400, 30);
    run_mode(1, 0, 300, 70);
    run_mode(0, 1, 300, 0);
    flush();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule